// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block drives the single active-low interrupt pin of a UART whose transmit and receive paths may run with or without FIFOs. It takes occupancy counts for the transmit and receive sides, a busy flag from the transmit shifter, and programmable trigger levels. From these it decides whether each side wants service. The meaning of "wants service" depends on two mode inputs: FIFO enable, and half-duplex auto-direction (RS-485) mode.

In RS-485 mode the transmit side must not ask for more data until the line can be turned around. So an empty transmit store alone is not enough; the shift register must also have drained. Each side's request is gated by its own enable, the two are ORed, and the result is registered so the pin never glitches.

With FIFOs off, the transmit level input is the holding-register occupancy and the receive level input is the receive-holding occupancy. In that mode, any nonzero value counts as "a byte present".

Top module: `uart_irq_pin`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `irq_n` is high after that edge.
- R2: `irq_n` is registered. It is low one clock after an edge where the transmit condition (gated by `tx_irq_en`) or the receive condition (gated by `rx_irq_en`) holds, and high otherwise. With both enables low it is high.
- R3: With `fifo_en`=0 and `rs485_en`=0, the transmit condition holds exactly when `tx_level` is zero. `tx_trig` has no effect in this mode.
- R4: With `fifo_en`=0 and `rs485_en`=1, the transmit condition holds exactly when `tx_level` is zero and `tx_shift_busy` is 0.
- R5: With `fifo_en`=1 and `rs485_en`=0, the transmit condition holds exactly when `tx_level` < `tx_trig`. A level equal to the trigger does not assert.
- R6: With `fifo_en`=1 and `rs485_en`=1, the transmit condition holds when 0 < `tx_level` < `tx_trig`, or when `tx_level` is zero and `tx_shift_busy` is 0.
- R7: With `fifo_en`=0, the receive condition holds exactly when `rx_level` is nonzero. `rx_trig` has no effect in this mode.
- R8: With `fifo_en`=1, the receive condition holds exactly when `rx_level` >= `rx_trig` and `rx_level` is nonzero. A level equal to the trigger asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rs485_en | input | 1 | Half-duplex auto-direction mode |
| tx_irq_en | input | 1 | Enable for the transmit request |
| rx_irq_en | input | 1 | Enable for the receive request |
| tx_level | input | LVL_W | Bytes waiting in transmit holding register or FIFO |
| tx_shift_busy | input | 1 | Transmit shift register still sending |
| rx_level | input | LVL_W | Bytes held in receive holding register or FIFO |
| tx_trig | input | LVL_W | Transmit trigger level |
| rx_trig | input | LVL_W | Receive trigger level |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The assertions assume that all inputs are stable around the rising edge and free of X once reset is released. They also assume reset is not reasserted in the cycle that an implication spans. The stimulus changes inputs only on the falling edge and holds reset low from time zero until the sweeps begin, which keeps within both assumptions. Trigger values range over the full level width, including zero and the maximum, so the equal-to-trigger boundaries are visited in every mode.

// File: rtl/uirq_pkg.sv
// Package: shared transmit-mode encoding for the interrupt pin generator.
// Assumes nothing beyond the two mode bits that select the variant.
package uirq_pkg;

    typedef enum logic [1:0] {
        TXM_HOLD       = 2'b00,   // single holding register
        TXM_HOLD_DRAIN = 2'b01,   // holding register plus shifter must drain
        TXM_FIFO       = 2'b10,   // FIFO below trigger
        TXM_FIFO_DRAIN = 2'b11    // FIFO below trigger, empty needs shifter idle
    } tx_mode_e;

    // Map the two configuration bits to a transmit mode.
    function automatic tx_mode_e pick_tx_mode(input logic fifo_on, input logic half_duplex);
        return tx_mode_e'({fifo_on, half_duplex});
    endfunction

endpackage

// File: rtl/uirq_tx_cond.sv
// Module: transmit service request.
// Decides whether the transmit side wants more data, based on the selected mode.
// Assumes tx_level counts bytes not yet handed to the shifter.
module uirq_tx_cond
    import uirq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  tx_mode_e           mode,
    input  logic [LVL_W-1:0]   level,
    input  logic [LVL_W-1:0]   trig,
    input  logic               shift_busy,
    output logic               want
);
    localparam logic [LVL_W-1:0] LVL_ZERO = '0;

    logic store_empty;
    logic below_trig;

    // Derive the basic level comparisons.
    always_comb begin
        store_empty = (level == LVL_ZERO);
        below_trig  = (level < trig);
    end

    // Select the request rule for the current mode.
    always_comb begin
        unique case (mode)
            TXM_HOLD:       want = store_empty;
            TXM_HOLD_DRAIN: want = store_empty && !shift_busy;
            TXM_FIFO:       want = below_trig;
            TXM_FIFO_DRAIN: want = (below_trig && !store_empty) ||
                                   (store_empty && !shift_busy);
            default:        want = 1'b0;
        endcase
    end
endmodule

// File: rtl/uirq_rx_cond.sv
// Module: receive service request.
// Asserts when received data is waiting, per the FIFO mode and trigger.
// Assumes rx_level counts bytes not yet read by the host.
module uirq_rx_cond #(
    parameter int LVL_W = 5
) (
    input  logic               fifo_on,
    input  logic [LVL_W-1:0]   level,
    input  logic [LVL_W-1:0]   trig,
    output logic               want
);
    localparam logic [LVL_W-1:0] LVL_ZERO = '0;

    logic has_data;

    // Any data present versus trigger reached.
    always_comb begin
        has_data = (level != LVL_ZERO);
        if (fifo_on) want = has_data && (level >= trig);
        else         want = has_data;
    end
endmodule

// File: rtl/uart_irq_pin.sv
// Module: UART interrupt pin generator (top).
// Combines the gated transmit and receive requests into a registered
// active-low pin. Assumes inputs are synchronous to clk.
module uart_irq_pin
    import uirq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rs485_en,
    input  logic             tx_irq_en,
    input  logic             rx_irq_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_shift_busy,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic [LVL_W-1:0] rx_trig,
    output logic             irq_n
);
    tx_mode_e tx_mode;
    logic     tx_want;
    logic     rx_want;
    logic     irq_any;

    // Decode the transmit mode from the configuration bits.
    always_comb tx_mode = pick_tx_mode(fifo_en, rs485_en);

    uirq_tx_cond #(.LVL_W(LVL_W)) tx_i (
        .mode       (tx_mode),
        .level      (tx_level),
        .trig       (tx_trig),
        .shift_busy (tx_shift_busy),
        .want       (tx_want)
    );

    uirq_rx_cond #(.LVL_W(LVL_W)) rx_i (
        .fifo_on (fifo_en),
        .level   (rx_level),
        .trig    (rx_trig),
        .want    (rx_want)
    );

    // Gate each request by its enable and merge.
    always_comb irq_any = (tx_irq_en && tx_want) || (rx_irq_en && rx_want);

    // Register the pin; idle high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= !irq_any;
    end
endmodule

// File: rtl/uart_irq_pin_chk.sv
// Checker: temporal properties of the interrupt pin generator, bound to the top.
// Assumes inputs are stable and known at each rising edge after reset.
module uart_irq_pin_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rs485_en,
    input logic             tx_irq_en,
    input logic             rx_irq_en,
    input logic [LVL_W-1:0] tx_level,
    input logic             tx_shift_busy,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_trig,
    input logic [LVL_W-1:0] rx_trig,
    input logic             irq_n
);
    localparam logic [LVL_W-1:0] Z = '0;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_irq_en && !rx_irq_en) |=> irq_n);

    assert_hold_full_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_irq_en && !rx_irq_en && tx_level != Z) |=> irq_n);

    assert_drain_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs485_en && tx_irq_en && !rx_irq_en && tx_level == Z && tx_shift_busy) |=> irq_n);

    assert_tx_at_trig_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !rs485_en && tx_irq_en && !rx_irq_en && tx_level == tx_trig) |=> irq_n);

    assert_rx_data_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_irq_en && rx_level != Z) |=> !irq_n);

    assert_rx_at_trig_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_irq_en && rx_level != Z && rx_level == rx_trig) |=> !irq_n);
endmodule

bind uart_irq_pin uart_irq_pin_chk #(.LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rs485_en(rs485_en),
    .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_level(tx_level),
    .tx_shift_busy(tx_shift_busy), .rx_level(rx_level), .tx_trig(tx_trig),
    .rx_trig(rx_trig), .irq_n(irq_n)
);

// File: tb/uart_irq_pin_tb_top.sv
// Bench: exhaustive sweeps of a 3-bit level configuration; expected pin
// computed from the requirements.
module uart_irq_pin_tb_top;
    localparam int W = 3;
    localparam int N = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 0, rs485_en = 0, tx_irq_en = 0, rx_irq_en = 0, tx_shift_busy = 0;
    logic [W-1:0] tx_level = '0, rx_level = '0, tx_trig = '0, rx_trig = '0;
    logic irq_n;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    uart_irq_pin #(.LVL_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rs485_en(rs485_en),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_level(tx_level),
        .tx_shift_busy(tx_shift_busy), .rx_level(rx_level), .tx_trig(tx_trig),
        .rx_trig(rx_trig), .irq_n(irq_n)
    );

    function automatic logic exp_tx(int fe, int rs, int lvl, int trg, int busy);
        if (!fe && !rs) return lvl == 0;                              // R3
        if (!fe &&  rs) return lvl == 0 && busy == 0;                 // R4
        if ( fe && !rs) return lvl < trg;                             // R5
        return (lvl > 0 && lvl < trg) || (lvl == 0 && busy == 0);     // R6
    endfunction

    function automatic logic exp_rx(int fe, int lvl, int trg);
        if (!fe) return lvl != 0;                                     // R7
        return lvl != 0 && lvl >= trg;                                // R8
    endfunction

    // Wait for the register to capture the inputs, then compare at the falling edge.
    task automatic check_pin(input logic exp, input string req);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq_n !== exp) begin
            fails++;
            $display("FAIL %s: irq_n=%b expected %b (fe=%0b rs=%0b te=%0b re=%0b tl=%0d tt=%0d b=%0b rl=%0d rt=%0d)",
                     req, irq_n, exp, fifo_en, rs485_en, tx_irq_en, rx_irq_en,
                     tx_level, tx_trig, tx_shift_busy, rx_level, rx_trig);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with conditions that would otherwise assert.
        tx_irq_en = 1; rx_irq_en = 1; rx_level = 3;
        @(negedge clk);
        check_pin(1'b1, "R1");
        check_pin(1'b1, "R1");
        rst_n = 1;

        // R2: both enables low.
        tx_irq_en = 0; rx_irq_en = 0;
        check_pin(1'b1, "R2");

        // Transmit sweep, receive disabled: R3..R6.
        tx_irq_en = 1; rx_irq_en = 0;
        for (int fe = 0; fe < 2; fe++)
            for (int rs = 0; rs < 2; rs++)
                for (int b = 0; b < 2; b++)
                    for (int l = 0; l < N; l++)
                        for (int t = 0; t < N; t++) begin
                            fifo_en = fe[0]; rs485_en = rs[0]; tx_shift_busy = b[0];
                            tx_level = W'(l); tx_trig = W'(t);
                            check_pin(!exp_tx(fe, rs, l, t, b),
                                      fe == 0 ? (rs == 0 ? "R3" : "R4") : (rs == 0 ? "R5" : "R6"));
                        end

        // Receive sweep, transmit disabled: R7, R8.
        tx_irq_en = 0; rx_irq_en = 1; rs485_en = 0;
        for (int fe = 0; fe < 2; fe++)
            for (int l = 0; l < N; l++)
                for (int t = 0; t < N; t++) begin
                    fifo_en = fe[0]; rx_level = W'(l); rx_trig = W'(t);
                    check_pin(!exp_rx(fe, l, t), fe == 0 ? "R7" : "R8");
                end

        // Combined sweep: OR of gated requests, R2.
        tx_trig = 4; rx_trig = 3; tx_shift_busy = 0;
        for (int fe = 0; fe < 2; fe++)
            for (int en = 0; en < 4; en++)
                for (int tl = 0; tl < N; tl++)
                    for (int rl = 0; rl < N; rl++) begin
                        fifo_en = fe[0]; tx_irq_en = en[0]; rx_irq_en = en[1];
                        tx_level = W'(tl); rx_level = W'(rl);
                        check_pin(!((en[0] && exp_tx(fe, 0, tl, 4, 0)) ||
                                    (en[1] && exp_rx(fe, rl, 3))), "R2");
                    end

        // R1 again: reset mid-run forces the pin high.
        tx_irq_en = 1; tx_level = 0; rst_n = 0;
        check_pin(1'b1, "R1");
        rst_n = 1;
        check_pin(1'b0, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule